// File: doc/BRIEF.md
# HDSL Receive Frame Aligner

This block follows the frame structure of a serial receive bit stream that runs at 784 kbit/s. Each frame opens with a 14-bit sync word. It ends either at bit 4702 or, when four stuff bits are appended, at bit 4706. The block counts bit positions from the moment the link enters its active state. It checks each sync word against a parameterised pattern and keeps a loss-of-sync-word flag with hysteresis: six bad words in a row raise it, and two good words in a row clear it.

Beside the retimed data, the block gives a downstream framer three timing marks. An active-low pulse marks the last bit of each frame. A window flag marks the sync and stuff positions. The loss flag gates the frame pulse. An upstream stuffing decision input is sampled on bit 4702 and sets the length of the frame. When the link is not active, the block forces its data output to ones and holds the loss flag high.

Top module: `hfa_top`

## Requirements
- R1: While active, on each clock with bitEn high, dataOut takes the value of rxBit on the next clock edge.
- R2: In reset, and on the clock after active goes low, dataOut is 1, frameN is 1, syncFlag is 0 and losw is 1. Bit counting restarts at position 1 when active returns.
- R3: stuffReq is sampled on bit 4702. If it is 0, the frame ends at bit 4702. If it is 1, the frame ends at bit 4706, and the next bit is bit 1 of a new frame.
- R4: frameN is low for exactly one bit period, on the last bit of a frame, and only while losw is low.
- R5: syncFlag is high on bits 1 to 14 of every frame and on stuff bits 4703 to 4706. After a stuffed frame this makes 18 bits in a row.
- R6: Bit 1 of the frame is compared with SYNC_WORD bit 13 and bit 14 with bit 0. Any single differing bit makes the word bad.
- R7: losw goes high on the output update of bit 14 of the sixth consecutive bad sync word.
- R8: A good sync word clears the count of bad words, so five bad words, then a good word, then five more bad words leave losw low.
- R9: losw goes low on the output update of bit 14 of the second consecutive good sync word, and not after the first.
- R10: While active, on clocks with bitEn low, all outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | Bit-rate enable, one per received bit |
| active | input | 1 | Link is in its active state |
| stuffReq | input | 1 | Current frame carries four stuff bits (sampled on bit 4702) |
| rxBit | input | 1 | Serial receive data |
| dataOut | output | 1 | Retimed receive data, ones when not active |
| frameN | output | 1 | Active-low pulse on the last bit of a frame |
| syncFlag | output | 1 | High on sync-word and stuff bit positions |
| losw | output | 1 | Loss of sync word |

## Verification
The hardest condition to reach is the hysteresis edge. A single good word sits inside a run of ten bad ones, and it must clear the miss run without clearing the loss state. The stimulus sends whole frames in sequence, one of them stuffed, and places mismatches at both the first and the last sync position. An independent bit-level model predicts every output for every bit, and bit enables are withheld every seventh bit so that the hold behaviour is also tested. Deactivating in the middle of a frame and then re-acquiring checks that counting restarts.

// File: rtl/hfa_pkg.sv
package hfa_pkg;
  typedef struct packed {
    logic step;     // bit accepted this cycle
    logic syncBit;  // current bit lies in the sync word
    logic syncRef;  // expected value of the current sync bit
    logic syncEnd;  // current bit is the last sync bit
    logic lastBit;  // current bit closes the frame
    logic flagWin;  // current bit is a sync or stuff position
  } hfaStrobe_t;
endpackage

// File: rtl/hfa_ctrl.sv
module hfa_ctrl
  import hfa_pkg::*;
#(
  parameter int FRAME_BITS = 4702,
  parameter int STUFF_BITS = 4,
  parameter int SYNC_BITS = 14,
  parameter logic [SYNC_BITS-1:0] SYNC_WORD = 14'h0F5A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       active,
  input  logic       stuffReq,
  output hfaStrobe_t strb
);
  localparam int MAX_BITS = FRAME_BITS + STUFF_BITS;
  localparam int POS_W = $clog2(MAX_BITS + 1);

  logic [POS_W-1:0] pos;
  logic [SYNC_BITS-1:0] refShift;
  logic atFrame, atTail, lastBit, inSync;

  always_comb begin
    atFrame = (pos == POS_W'(FRAME_BITS));
    atTail  = (pos == POS_W'(MAX_BITS));
    lastBit = (atFrame && !stuffReq) || atTail;
    inSync  = (pos <= POS_W'(SYNC_BITS));
    strb.step    = bitEn && active;
    strb.syncBit = inSync;
    strb.syncRef = refShift[SYNC_BITS-1];
    strb.syncEnd = (pos == POS_W'(SYNC_BITS));
    strb.lastBit = lastBit;
    strb.flagWin = inSync || (pos > POS_W'(FRAME_BITS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos      <= POS_W'(1);
      refShift <= SYNC_WORD;
    end else if (!active) begin
      pos      <= POS_W'(1);
      refShift <= SYNC_WORD;
    end else if (bitEn) begin
      if (lastBit) begin
        pos      <= POS_W'(1);
        refShift <= SYNC_WORD;
      end else begin
        pos      <= pos + 1'b1;
        refShift <= {refShift[SYNC_BITS-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/hfa_dpath.sv
module hfa_dpath
  import hfa_pkg::*;
#(
  parameter int LOSS_COUNT = 6,
  parameter int GAIN_COUNT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       active,
  input  logic       rxBit,
  input  hfaStrobe_t strb,
  output logic       dataOut,
  output logic       frameN,
  output logic       syncFlag,
  output logic       losw
);
  localparam int CNT_W = $clog2(LOSS_COUNT + GAIN_COUNT + 1);

  logic [CNT_W-1:0] missCnt, hitCnt;
  logic wordOk, okNow;

  assign okNow = wordOk && (rxBit == strb.syncRef);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= 1'b1; frameN <= 1'b1; syncFlag <= 1'b0; losw <= 1'b1;
      wordOk <= 1'b1; missCnt <= '0; hitCnt <= '0;
    end else if (!active) begin
      dataOut <= 1'b1; frameN <= 1'b1; syncFlag <= 1'b0; losw <= 1'b1;
      wordOk <= 1'b1; missCnt <= '0; hitCnt <= '0;
    end else if (strb.step) begin
      dataOut  <= rxBit;
      syncFlag <= strb.flagWin;
      frameN   <= !(strb.lastBit && !losw);
      if (strb.syncBit) begin
        if (strb.syncEnd) begin
          wordOk <= 1'b1;
          if (okNow) begin
            missCnt <= '0;
            if (hitCnt < CNT_W'(GAIN_COUNT)) hitCnt <= hitCnt + 1'b1;
            if (hitCnt >= CNT_W'(GAIN_COUNT - 1)) losw <= 1'b0;
          end else begin
            hitCnt <= '0;
            if (missCnt < CNT_W'(LOSS_COUNT)) missCnt <= missCnt + 1'b1;
            if (missCnt >= CNT_W'(LOSS_COUNT - 1)) losw <= 1'b1;
          end
        end else begin
          wordOk <= okNow;
        end
      end
    end
  end
endmodule

// File: rtl/hfa_top.sv
module hfa_top
  import hfa_pkg::*;
#(
  parameter int FRAME_BITS = 4702,
  parameter int STUFF_BITS = 4,
  parameter int SYNC_BITS = 14,
  parameter logic [SYNC_BITS-1:0] SYNC_WORD = 14'h0F5A,
  parameter int LOSS_COUNT = 6,
  parameter int GAIN_COUNT = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic active,
  input  logic stuffReq,
  input  logic rxBit,
  output logic dataOut,
  output logic frameN,
  output logic syncFlag,
  output logic losw
);
  hfaStrobe_t strb;

  hfa_ctrl #(
    .FRAME_BITS(FRAME_BITS), .STUFF_BITS(STUFF_BITS),
    .SYNC_BITS(SYNC_BITS), .SYNC_WORD(SYNC_WORD)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .active(active),
    .stuffReq(stuffReq), .strb(strb)
  );

  hfa_dpath #(
    .LOSS_COUNT(LOSS_COUNT), .GAIN_COUNT(GAIN_COUNT)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .active(active), .rxBit(rxBit), .strb(strb),
    .dataOut(dataOut), .frameN(frameN), .syncFlag(syncFlag), .losw(losw)
  );
endmodule

// File: rtl/hfa_checker.sv
module hfa_checker (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic active,
  input logic rxBit,
  input logic dataOut,
  input logic frameN,
  input logic syncFlag,
  input logic losw
);
  // R1: retimed data follows the accepted bit
  a_r1_data_follows: assert property (@(posedge clk) disable iff (!rstN)
    (active && bitEn) |=> (dataOut == $past(rxBit)));

  // R2: inactive state forces every output
  a_r2_forced_idle: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (dataOut && frameN && !syncFlag && losw));

  // R4: frame pulse only while sync is held
  a_r4_pulse_gated: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |-> !losw);

  // R4: pulse lasts one bit only
  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    (!frameN && bitEn && active) |=> frameN);

  // R10: no bit enable, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (active && !bitEn) |=> ($stable(dataOut) && $stable(frameN) &&
                            $stable(syncFlag) && $stable(losw)));
endmodule

bind hfa_top hfa_checker chk_i (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .active(active), .rxBit(rxBit),
  .dataOut(dataOut), .frameN(frameN), .syncFlag(syncFlag), .losw(losw)
);

// File: tb/hfa_top_tb.sv
module hfa_top_tb_top;
  localparam int FB = 4702;
  localparam int SB = 4;
  localparam int SY = 14;
  localparam logic [SY-1:0] SYNC = 14'h0F5A;

  typedef struct packed {
    logic d; logic fn; logic fl; logic lw;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic active = 1'b0;
  logic stuffReq = 1'b0;
  logic rxBit = 1'b0;
  logic dataOut, frameN, syncFlag, losw;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string phase = "reset";
  expItem_t q[$];

  // bench model state
  int mPos = 1;
  logic mOk = 1'b1;
  int mMiss = 0;
  int mHit = 0;
  logic mLosw = 1'b1;
  int bitCount = 0;
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  hfa_top dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .active(active),
    .stuffReq(stuffReq), .rxBit(rxBit), .dataOut(dataOut),
    .frameN(frameN), .syncFlag(syncFlag), .losw(losw)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (%s) actual=%b expected=%b", tag, phase, act, exp);
    end
  endtask

  task automatic modelReset();
    mPos = 1; mOk = 1'b1; mMiss = 0; mHit = 0; mLosw = 1'b1;
  endtask

  task automatic sendBit(input logic b, input logic stuff, input logic [SY-1:0] word);
    expItem_t e;
    logic last;
    bitCount++;
    if (bitCount % 7 == 0) begin
      bitEn = 1'b0; rxBit = ~b; stuffReq = ~stuff;
      @(negedge clk);
    end
    last = ((mPos == FB) && !stuff) || (mPos == FB + SB);
    e.d  = b;
    e.fl = (mPos <= SY) || (mPos > FB);
    e.fn = !(last && !mLosw);
    if (mPos <= SY) begin
      mOk = mOk && (b == SYNC[SY-mPos]);
      if (mPos == SY) begin
        if (mOk) begin
          mMiss = 0;
          if (mHit < 2) mHit++;
          if (mHit >= 2) mLosw = 1'b0;
        end else begin
          mHit = 0;
          if (mMiss < 6) mMiss++;
          if (mMiss >= 6) mLosw = 1'b1;
        end
        mOk = 1'b1;
      end
    end
    e.lw = mLosw;
    mPos = last ? 1 : mPos + 1;
    q.push_back(e);
    bitEn = 1'b1; rxBit = b; stuffReq = stuff;
    @(negedge clk);
  endtask

  task automatic sendFrame(input logic [SY-1:0] word, input logic stuff, input int count);
    int len;
    len = stuff ? FB + SB : FB;
    if (count > 0 && count < len) len = count;
    for (int p = 1; p <= len; p++) begin
      logic b;
      if (p <= SY) b = word[SY-p];
      else begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        b = lf[0];
      end
      sendBit(b, stuff, word);
    end
    bitEn = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    logic fire, idle, haveLast;
    expItem_t lastObs, e;
    haveLast = 1'b0;
    lastObs = '0;
    forever begin
      @(posedge clk);
      fire = bitEn && active && rstN;
      idle = active && !bitEn && rstN;
      @(negedge clk);
      if (fire) begin
        if (q.size() == 0) begin
          chk("R1 queue", 1'b0, 1'b1);
        end else begin
          e = q.pop_front();
          chk("R1 dataOut", dataOut, e.d);
          chk("R4 frameN", frameN, e.fn);
          chk("R5 syncFlag", syncFlag, e.fl);
          chk("R7 losw", losw, e.lw);
        end
      end else if (idle && haveLast) begin
        chk("R10 hold dataOut", dataOut, lastObs.d);
        chk("R10 hold frameN", frameN, lastObs.fn);
        chk("R10 hold syncFlag", syncFlag, lastObs.fl);
        chk("R10 hold losw", losw, lastObs.lw);
      end
      lastObs = '{d: dataOut, fn: frameN, fl: syncFlag, lw: losw};
      haveLast = 1'b1;
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    phase = "R2 reset state";
    chk("R2 reset dataOut", dataOut, 1'b1);
    chk("R2 reset frameN", frameN, 1'b1);
    chk("R2 reset syncFlag", syncFlag, 1'b0);
    chk("R2 reset losw", losw, 1'b1);
    rstN = 1'b1;
    phase = "R2 inactive data ignored";
    bitEn = 1'b1; rxBit = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 inactive dataOut", dataOut, 1'b1);
    chk("R2 inactive losw", losw, 1'b1);
    bitEn = 1'b0;
    @(negedge clk);
    active = 1'b1;
    @(negedge clk);

    phase = "R9 first good word";
    sendFrame(SYNC, 1'b0, 0);
    chk("R9 one good word keeps loss", losw, 1'b1);
    phase = "R3 R5 R9 stuffed frame second good word";
    sendFrame(SYNC, 1'b1, 0);
    chk("R9 two good words clear loss", losw, 1'b0);
    phase = "R3 R4 unstuffed frame";
    sendFrame(SYNC, 1'b0, 0);
    phase = "R6 mismatch in last sync bit";
    for (int i = 0; i < 3; i++) sendFrame(SYNC ^ 14'h0001, 1'b0, 0);
    phase = "R6 mismatch in first sync bit";
    for (int i = 0; i < 2; i++) sendFrame(SYNC ^ 14'h2000, 1'b1, 0);
    chk("R7 five bad words keep sync", losw, 1'b0);
    phase = "R8 good word between bad runs";
    sendFrame(SYNC, 1'b1, 0);
    for (int i = 0; i < 5; i++) sendFrame(SYNC ^ 14'h0100, 1'b0, 0);
    chk("R8 run cleared by good word", losw, 1'b0);
    phase = "R7 sixth bad word";
    sendFrame(SYNC ^ 14'h0040, 1'b0, 0);
    chk("R7 six bad words raise loss", losw, 1'b1);
    phase = "R9 recovery";
    sendFrame(SYNC, 1'b0, 0);
    chk("R9 recovery one good word", losw, 1'b1);
    sendFrame(SYNC, 1'b1, 0);
    chk("R9 recovery two good words", losw, 1'b0);

    phase = "R2 deactivate mid-frame";
    sendFrame(SYNC, 1'b0, 100);
    active = 1'b0;
    @(negedge clk);
    modelReset();
    chk("R2 forced dataOut", dataOut, 1'b1);
    chk("R2 forced frameN", frameN, 1'b1);
    chk("R2 forced syncFlag", syncFlag, 1'b0);
    chk("R2 forced losw", losw, 1'b1);
    @(negedge clk);
    active = 1'b1;
    phase = "R2 restart counting";
    sendFrame(SYNC, 1'b0, 0);
    sendFrame(SYNC, 1'b0, 0);
    chk("R2 restart acquires sync", losw, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 scoreboard drained", (q.size() == 0), 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule